// File: doc/BRIEF.md
# Peripheral Interrupt Enable, Pending and Priority Register Bank

This block holds the per-source control state for the peripheral interrupt sources of an interrupt controller. Each source has an enable bit, a pending bit and an 8-bit priority byte. A downstream priority resolver reads these as flat vectors. Software reaches the state through a simple single-cycle register port. Enable and pending each have a pair of word addresses: one that sets the bits written as 1 and one that clears them. A trigger register takes a source index and raises that source's request from software.

Request lines from the peripherals set pending bits. A request may be a level or a single-cycle pulse. When the resolver starts servicing a source it raises an acknowledge with the source index, and that source's pending bit is cleared. Peripheral source p is interrupt number p+16 in the global numbering. Its bit is bit p mod 32 of array word p/32.

The register port has no back-pressure. Every access completes in the cycle it is presented, and the bank never stalls the requester. Writes take effect at the next rising edge. Read data is combinational from the addressed word, so it is valid in the same cycle the address is presented. By default there are 160 sources, which fill five array words. NUM_SRC must be a multiple of 32 and at most 256.

Top module: `irq_reg_bank`

## Requirements
- R1: A synchronous active-high reset clears every enable bit, every pending bit and every priority byte, so every mapped word reads 0.
- R2: A write to enable-set word w (word address w, for w = 0..NUM_SRC/32-1) enables source 32w+b for every data bit b that is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to enable-clear word w (word address 8+w) disables source 32w+b for every data bit b that is 1. Bits written as 0 leave their enables unchanged.
- R4: A read of enable-set word w or of enable-clear word w returns the current enable bits of sources 32w..32w+31, with source 32w in bit 0.
- R5: A write to pend-set word w (word address 16+w) makes source 32w+b pending for every data bit b that is 1. A read of pend-set word w or pend-clear word w (word address 24+w) returns the pending bits of that word.
- R6: A write to pend-clear word w discards the pending bit of source 32w+b for every data bit b that is 1. When ack_valid is high, the pending bit of source ack_id is cleared at that clock edge. An ack_id of NUM_SRC or more has no effect.
- R7: A high irq_in[p] makes source p pending at the next edge. The request wins over a pend-clear write or an acknowledge to the same source in the same cycle.
- R8: Writing value k to the trigger register (word address 32) makes source k pending, exactly as if irq_in[k] had been high for one cycle. A value of NUM_SRC or more changes nothing. The trigger register reads as 0.
- R9: Priority word q (word address 64+q) holds sources 4q..4q+3, with source 4q+l in byte lane l (bits 8l+7..8l). Only bits 7..5 of each byte are stored. Bits 4..0 read as 0, both on the bus and on prio_vec.
- R10: Reads of unmapped word addresses return 0. Writes to unmapped word addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for the register port |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word, combinational |
| irq_in | input | NUM_SRC (160) | Request line per source, level or pulse |
| ack_valid | input | 1 | Resolver acknowledges a source this cycle |
| ack_id | input | clog2(NUM_SRC) (8) | Peripheral index of the acknowledged source |
| en_vec | output | NUM_SRC (160) | Enable bit per source |
| pend_vec | output | NUM_SRC (160) | Pending bit per source |
| prio_vec | output | 8*NUM_SRC (1280) | Priority byte per source, source p in bits 8p+7..8p |

## Verification
Writes, requests, triggers and acknowledges are registered once. Their effect is therefore due on en_vec, pend_vec, prio_vec and on the read data of the next cycle, one rising edge after the stimulus is presented. bus_rdata has no register of its own, so it reflects the addressed word in the cycle the address is shown. The bench updates its behavioural model at each rising edge from the inputs it presented before that edge. It then compares all three vectors and the read data at the following falling edge. Directed reads are sampled a few nanoseconds after the address changes, within the same low phase.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int DATA_W      = 32;
  localparam int ADDR_W      = 7;
  localparam int IDX_W       = 6;
  // word address map; each array region has room for eight words
  localparam int EN_SET_BASE = 0;
  localparam int EN_CLR_BASE = 8;
  localparam int PD_SET_BASE = 16;
  localparam int PD_CLR_BASE = 24;
  localparam int TRIG_ADDR   = 32;
  localparam int PRIO_BASE   = 64;

  typedef enum logic [2:0] {
    RG_NONE,
    RG_EN,
    RG_PEND,
    RG_TRIG,
    RG_PRIO
  } region_e;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int NUM_WORDS  = 5,
  parameter int NUM_PWORDS = 40
) (
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [NUM_WORDS-1:0]  en_set_sel,
  output logic [NUM_WORDS-1:0]  en_clr_sel,
  output logic [NUM_WORDS-1:0]  pd_set_sel,
  output logic [NUM_WORDS-1:0]  pd_clr_sel,
  output logic [NUM_PWORDS-1:0] prio_sel,
  output logic                  trig_we,
  output region_e               rd_region,
  output logic [IDX_W-1:0]      rd_idx
);
  logic we;
  assign we      = bus_sel && bus_wr;
  assign trig_we = we && (bus_addr == ADDR_W'(TRIG_ADDR));

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    assign en_set_sel[w] = we && (bus_addr == ADDR_W'(EN_SET_BASE + w));
    assign en_clr_sel[w] = we && (bus_addr == ADDR_W'(EN_CLR_BASE + w));
    assign pd_set_sel[w] = we && (bus_addr == ADDR_W'(PD_SET_BASE + w));
    assign pd_clr_sel[w] = we && (bus_addr == ADDR_W'(PD_CLR_BASE + w));
  end

  for (genvar q = 0; q < NUM_PWORDS; q++) begin : g_pword
    assign prio_sel[q] = we && (bus_addr == ADDR_W'(PRIO_BASE + q));
  end

  always_comb begin
    int a;
    a         = int'(bus_addr);
    rd_region = RG_NONE;
    rd_idx    = '0;
    if (a >= EN_SET_BASE && a < EN_SET_BASE + NUM_WORDS) begin
      rd_region = RG_EN;
      rd_idx    = IDX_W'(a - EN_SET_BASE);
    end else if (a >= EN_CLR_BASE && a < EN_CLR_BASE + NUM_WORDS) begin
      rd_region = RG_EN;
      rd_idx    = IDX_W'(a - EN_CLR_BASE);
    end else if (a >= PD_SET_BASE && a < PD_SET_BASE + NUM_WORDS) begin
      rd_region = RG_PEND;
      rd_idx    = IDX_W'(a - PD_SET_BASE);
    end else if (a >= PD_CLR_BASE && a < PD_CLR_BASE + NUM_WORDS) begin
      rd_region = RG_PEND;
      rd_idx    = IDX_W'(a - PD_CLR_BASE);
    end else if (a == TRIG_ADDR) begin
      rd_region = RG_TRIG;
    end else if (a >= PRIO_BASE && a < PRIO_BASE + NUM_PWORDS) begin
      rd_region = RG_PRIO;
      rd_idx    = IDX_W'(a - PRIO_BASE);
    end
  end
endmodule

// File: rtl/irq_bit_array.sv
module irq_bit_array
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 160,
  localparam int NUM_WORDS = NUM_SRC / 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_WORDS-1:0] set_sel,
  input  logic [NUM_WORDS-1:0] clr_sel,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_SRC-1:0]   hw_set,
  input  logic [NUM_SRC-1:0]   hw_clr,
  output logic [NUM_SRC-1:0]   bits
);
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] q, set_m, clr_m;
    assign set_m = (set_sel[w] ? wdata : 32'h0) | hw_set[32*w +: 32];
    assign clr_m = (clr_sel[w] ? wdata : 32'h0) | hw_clr[32*w +: 32];
    // any set source wins over any clear source on the same bit
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= (q & ~clr_m) | set_m;
    end
    assign bits[32*w +: 32] = q;
  end
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store #(
  parameter int NUM_SRC   = 160,
  parameter int PRIO_BITS = 3,
  localparam int NUM_PWORDS = NUM_SRC / 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_PWORDS-1:0]  prio_sel,
  input  logic [4*PRIO_BITS-1:0] wbits,
  output logic [8*NUM_SRC-1:0]   prio_vec
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PRIO_BITS-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                q <= '0;
      else if (prio_sel[i/4]) q <= wbits[(i%4)*PRIO_BITS +: PRIO_BITS];
    end
    assign prio_vec[8*i +: 8] = {q, {(8-PRIO_BITS){1'b0}}};
  end
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC   = 160,
  parameter int PRIO_BITS = 3,
  localparam int ID_W     = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  output logic [NUM_SRC-1:0]   en_vec,
  output logic [NUM_SRC-1:0]   pend_vec,
  output logic [8*NUM_SRC-1:0] prio_vec
);
  localparam int NUM_WORDS  = NUM_SRC / 32;
  localparam int NUM_PWORDS = NUM_SRC / 4;

  logic [NUM_WORDS-1:0]  en_set_sel, en_clr_sel, pd_set_sel, pd_clr_sel;
  logic [NUM_PWORDS-1:0] prio_sel;
  logic                  trig_we;
  region_e               rd_region;
  logic [IDX_W-1:0]      rd_idx;
  logic [NUM_SRC-1:0]    trig_hit, ack_hit, pd_hw_set, no_hw;
  logic [4*PRIO_BITS-1:0] prio_wbits;

  irq_bank_decode #(.NUM_WORDS(NUM_WORDS), .NUM_PWORDS(NUM_PWORDS)) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .en_set_sel(en_set_sel), .en_clr_sel(en_clr_sel),
    .pd_set_sel(pd_set_sel), .pd_clr_sel(pd_clr_sel),
    .prio_sel(prio_sel), .trig_we(trig_we),
    .rd_region(rd_region), .rd_idx(rd_idx)
  );

  // one-hot decode of the trigger index and the acknowledged source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign trig_hit[i] = trig_we && (bus_wdata == DATA_W'(i));
    assign ack_hit[i]  = ack_valid && (ack_id == ID_W'(i));
  end

  assign pd_hw_set = irq_in | trig_hit;
  assign no_hw     = '0;

  irq_bit_array #(.NUM_SRC(NUM_SRC)) u_enable (
    .clk(clk), .rst(rst), .set_sel(en_set_sel), .clr_sel(en_clr_sel),
    .wdata(bus_wdata), .hw_set(no_hw), .hw_clr(no_hw), .bits(en_vec)
  );

  irq_bit_array #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .set_sel(pd_set_sel), .clr_sel(pd_clr_sel),
    .wdata(bus_wdata), .hw_set(pd_hw_set), .hw_clr(ack_hit), .bits(pend_vec)
  );

  // only the top PRIO_BITS of each byte lane are kept
  for (genvar l = 0; l < 4; l++) begin : g_lane
    assign prio_wbits[l*PRIO_BITS +: PRIO_BITS] = bus_wdata[8*l + 8 - PRIO_BITS +: PRIO_BITS];
  end

  irq_prio_store #(.NUM_SRC(NUM_SRC), .PRIO_BITS(PRIO_BITS)) u_prio (
    .clk(clk), .rst(rst), .prio_sel(prio_sel), .wbits(prio_wbits), .prio_vec(prio_vec)
  );

  always_comb begin
    case (rd_region)
      RG_EN:   bus_rdata = en_vec[32*int'(rd_idx) +: 32];
      RG_PEND: bus_rdata = pend_vec[32*int'(rd_idx) +: 32];
      RG_PRIO: bus_rdata = prio_vec[32*int'(rd_idx) +: 32];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_reg_bank_chk.sv
module irq_reg_bank_chk
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 160,
  localparam int ID_W   = $clog2(NUM_SRC)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [NUM_SRC-1:0]   irq_in,
  input logic                 ack_valid,
  input logic [ID_W-1:0]      ack_id,
  input logic [NUM_SRC-1:0]   en_vec,
  input logic [NUM_SRC-1:0]   pend_vec
);
  localparam int NUM_WORDS = NUM_SRC / 32;
  localparam logic [1:0] K_NONE = 2'd0, K_ENSET = 2'd1, K_ENCLR = 2'd2, K_PDCLR = 2'd3;

  logic        we;
  logic [1:0]  kind, q_kind;
  int          widx, q_idx;
  logic [31:0] q_data, q_req, en_word, pd_word;

  assign we = bus_sel && bus_wr;

  always_comb begin
    int a;
    a    = int'(bus_addr);
    kind = K_NONE;
    widx = 0;
    if (we && a >= EN_SET_BASE && a < EN_SET_BASE + NUM_WORDS) begin
      kind = K_ENSET; widx = a - EN_SET_BASE;
    end else if (we && a >= EN_CLR_BASE && a < EN_CLR_BASE + NUM_WORDS) begin
      kind = K_ENCLR; widx = a - EN_CLR_BASE;
    end else if (we && a >= PD_CLR_BASE && a < PD_CLR_BASE + NUM_WORDS) begin
      kind = K_PDCLR; widx = a - PD_CLR_BASE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_kind <= K_NONE;
      q_idx  <= 0;
      q_data <= '0;
      q_req  <= '0;
    end else begin
      q_kind <= kind;
      q_idx  <= widx;
      q_data <= bus_wdata;
      q_req  <= irq_in[32*widx +: 32];
    end
  end

  assign en_word = en_vec[32*q_idx +: 32];
  assign pd_word = pend_vec[32*q_idx +: 32];

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
    (q_kind == K_ENSET) |-> ((en_word & q_data) == q_data)); // R2
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (q_kind == K_ENCLR) |-> ((en_word & q_data) == 32'h0)); // R3
  AST_PEND_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
    (q_kind == K_PDCLR) |-> ((pd_word & q_data & ~q_req) == 32'h0)); // R6
  AST_REQ_PENDS: assert property (@(posedge clk) disable iff (rst)
    (|irq_in) |=> ((pend_vec & $past(irq_in)) == $past(irq_in))); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && int'(ack_id) < NUM_SRC && !irq_in[ack_id] && !we) |=> !pend_vec[$past(ack_id)]); // R6
endmodule

bind irq_reg_bank irq_reg_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_in(irq_in), .ack_valid(ack_valid), .ack_id(ack_id),
  .en_vec(en_vec), .pend_vec(pend_vec)
);

// File: tb/irq_reg_bank_test.sv
module irq_reg_bank_test;
  localparam int NS = 160;

  logic            clk = 1'b0;
  logic            rst;
  logic            bus_sel, bus_wr;
  logic [6:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NS-1:0]   irq_in;
  logic            ack_valid;
  logic [7:0]      ack_id;
  logic [NS-1:0]   en_vec, pend_vec;
  logic [8*NS-1:0] prio_vec;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic [NS-1:0] m_en, m_pd;
  logic [7:0]    m_pr [NS];

  always #10 clk = ~clk;

  irq_reg_bank uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_id(ack_id), .en_vec(en_vec), .pend_vec(pend_vec),
    .prio_vec(prio_vec)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(input int a);
    logic [31:0] r;
    r = '0;
    if (a < 5)                    r = m_en[32*a +: 32];
    else if (a >= 8 && a < 13)    r = m_en[32*(a-8) +: 32];
    else if (a >= 16 && a < 21)   r = m_pd[32*(a-16) +: 32];
    else if (a >= 24 && a < 29)   r = m_pd[32*(a-24) +: 32];
    else if (a >= 64 && a < 104)
      for (int l = 0; l < 4; l++) r[8*l +: 8] = m_pr[4*(a-64)+l];
    return r;
  endfunction

  task automatic model_step();
    int a;
    a = int'(bus_addr);
    if (rst) begin
      m_en = '0; m_pd = '0;
      for (int i = 0; i < NS; i++) m_pr[i] = 8'h00;
      return;
    end
    // clears first, then anything that sets
    if (bus_sel && bus_wr) begin
      for (int b = 0; b < 32; b++) if (bus_wdata[b]) begin
        if (a < 5)                  m_en[32*a+b] = 1'b1;
        if (a >= 8 && a < 13)       m_en[32*(a-8)+b] = 1'b0;
        if (a >= 24 && a < 29)      m_pd[32*(a-24)+b] = 1'b0;
      end
      if (a >= 64 && a < 104)
        for (int l = 0; l < 4; l++) m_pr[4*(a-64)+l] = bus_wdata[8*l +: 8] & 8'hE0;
    end
    if (ack_valid && int'(ack_id) < NS) m_pd[ack_id] = 1'b0;
    if (bus_sel && bus_wr) begin
      if (a >= 16 && a < 21)
        for (int b = 0; b < 32; b++) if (bus_wdata[b]) m_pd[32*(a-16)+b] = 1'b1;
      if (a == 32 && bus_wdata < NS) m_pd[bus_wdata] = 1'b1;
    end
    m_pd = m_pd | irq_in;
  endtask

  task automatic compare_all();
    bit ok;
    check(en_vec == m_en, "R2 R3 en_vec", en_vec[31:0], m_en[31:0]);
    check(pend_vec == m_pd, "R5 R6 R7 R8 pend_vec", pend_vec[31:0], m_pd[31:0]);
    ok = 1'b1;
    for (int i = 0; i < NS; i++) if (prio_vec[8*i +: 8] !== m_pr[i]) ok = 1'b0;
    check(ok, "R9 prio_vec", prio_vec[31:0], {m_pr[3], m_pr[2], m_pr[1], m_pr[0]});
    check(bus_rdata === model_rd(int'(bus_addr)), "R4 R10 bus_rdata", bus_rdata, model_rd(int'(bus_addr)));
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 7'(a);
    #2;
    check(bus_rdata === exp, tag, bus_rdata, exp);
    tick();
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NS-1:0] snap;
    rst = 1'b1; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    irq_in = '0; ack_valid = 0; ack_id = '0;
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    rd_chk(0, 32'h0, "R1 enable word 0 after reset");
    rd_chk(16, 32'h0, "R1 pend word 0 after reset");
    rd_chk(64, 32'h0, "R1 prio word 0 after reset");

    // R2 / R3 / R4
    wr(0, 32'h0000_00F0);
    rd_chk(0, 32'h0000_00F0, "R2 R4 enable set word 0");
    rd_chk(8, 32'h0000_00F0, "R4 enable read via clear address");
    wr(0, 32'h0000_0001);
    rd_chk(0, 32'h0000_00F1, "R2 zeros leave enables");
    wr(8, 32'h0000_0030);
    rd_chk(0, 32'h0000_00C1, "R3 enable clear");
    wr(4, 32'h8000_0000);
    check(en_vec[159] == 1'b1, "R2 last source enabled", 32'(en_vec[159]), 32'h1);

    // R5 / R6
    wr(17, 32'h0000_0005);
    rd_chk(17, 32'h0000_0005, "R5 pend set word 1");
    wr(25, 32'h0000_0001);
    rd_chk(25, 32'h0000_0004, "R6 pend clear word 1");

    // R7 pulse request, then request against a pend-clear write
    irq_in[40] = 1'b1; tick(); irq_in[40] = 1'b0;
    rd_chk(17, 32'h0000_0104, "R7 pulse request pends");
    irq_in[33] = 1'b1;
    wr(25, 32'hFFFF_FFFF);
    irq_in[33] = 1'b0;
    rd_chk(17, 32'h0000_0002, "R7 request beats pend clear");
    ack_valid = 1'b1; ack_id = 8'd33; tick(); ack_valid = 1'b0;
    rd_chk(17, 32'h0000_0000, "R6 acknowledge clears");
    irq_in[33] = 1'b1; ack_valid = 1'b1; ack_id = 8'd33; tick();
    irq_in[33] = 1'b0; ack_valid = 1'b0;
    rd_chk(17, 32'h0000_0002, "R7 request beats acknowledge");
    ack_valid = 1'b1; ack_id = 8'd200; tick(); ack_valid = 1'b0;
    rd_chk(17, 32'h0000_0002, "R6 out-of-range acknowledge ignored");

    // R8 software trigger
    wr(32, 32'd70);
    rd_chk(18, 32'h0000_0040, "R8 trigger source 70");
    rd_chk(32, 32'h0, "R8 trigger reads zero");
    snap = pend_vec;
    wr(32, 32'd200);
    check(pend_vec == snap, "R8 out-of-range trigger ignored", pend_vec[95:64], snap[95:64]);

    // R9 priorities
    wr(67, 32'hFFA0_5F3E);
    rd_chk(67, 32'hE0A0_4020, "R9 priority word 3 lanes");
    check(prio_vec[8*14 +: 8] == 8'hA0, "R9 source 14 byte", 32'(prio_vec[8*14 +: 8]), 32'hA0);
    wr(103, 32'h1234_5678);
    rd_chk(103, 32'h0020_4060, "R9 last priority word");

    // R10 unmapped
    wr(45, 32'hFFFF_FFFF);
    rd_chk(45, 32'h0, "R10 unmapped read");
    rd_chk(0, 32'h0000_00C1, "R10 unmapped write left enables");

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      bus_sel   = ($urandom % 2) == 0;
      bus_wr    = ($urandom % 3) != 0;
      bus_addr  = 7'($urandom_range(0, 105));
      bus_wdata = (bus_addr == 7'd32) ? 32'($urandom_range(0, 180)) : $urandom;
      irq_in    = '0;
      if ($urandom % 3 == 0) irq_in[$urandom_range(0, NS-1)] = 1'b1;
      ack_valid = ($urandom % 3) == 0;
      ack_id    = 8'($urandom_range(0, 165));
      tick();
    end
    bus_sel = 0; bus_wr = 0; irq_in = '0; ack_valid = 0;
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule